// File: doc/BRIEF.md
# Wake Frame Detector

This block watches the bytes of received frames and decides whether a frame is a wake-up frame meant for this station. It first screens the destination address against an acceptance policy. Depending on one control bit, the policy is exact station match only, or station match plus any group (multicast or broadcast) address. Behind the address it searches the rest of the frame for a wake pattern. The pattern is a run of all-ones bytes followed by back-to-back copies of the station's own 48-bit address.

When a screened frame carries the complete pattern by the time it ends, a sticky status flag is set. The host clears the flag with a write-one-to-clear pulse. The flag drives three kinds of indication, each through its own enables: an interrupt, a power-management event and a set of LED outputs. CRC checking and frame delimiting are done upstream; this block only sees byte strobes and start/end markers.

Top module: `mpkt_wake_det`

## Requirements
- R1: With `accept_grp` low, a frame qualifies only if its first six bytes equal the station address. The first wire byte is compared with `stn_mac[7:0]`, and byte k with `stn_mac[8k+7:8k]`.
- R2: With `accept_grp` high, a frame also qualifies when bit 0 of its first byte is 1, which covers any multicast address and the broadcast address.
- R3: Bytes from the seventh on are searched for six 0xFF bytes followed by sixteen consecutive copies of the station address (96 bytes). The rules for each byte are:
  - A byte equal to the expected address byte always advances the search.
  - Extra 0xFF bytes before the first copy are allowed.
  - Any other mismatch restarts the search, and the mismatching byte counts as the first sync byte if it is 0xFF.
- R4: The address copies are always matched against the station address, whatever `accept_grp` is and whatever type the destination address is.
- R5: `rx_sof` and `rx_eof` accompany the first and last byte of a frame with `rx_vld` high. The decision is taken at end of frame, and the byte in the `rx_eof` cycle is part of the frame. `wake_flag` rises in the cycle after that edge only if the pattern was complete. A new `rx_sof` discards any partial search.
- R6: `wake_flag` stays set until a cycle with `flag_clr` high, and is low from the next cycle on. If a set and a clear fall in the same cycle, the set wins.
- R7: `irq_o` is high exactly when `wake_flag`, `irq_glb_en` and `irq_wake_en` are all high.
- R8: `pme_o` is high exactly when `wake_flag`, `pme_glb_en` and `pme_wake_en` are all high.
- R9: `led_o[i]` is high exactly when `wake_flag` and `led_wake_sel[i]` are high.
- R10: After reset, `wake_flag`, `irq_o`, `pme_o` and `led_o` are all low, whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_vld | input | 1 | Byte strobe |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_byte | input | 8 | Received byte |
| stn_mac | input | 48 | Station address, first wire byte in bits 7:0 |
| accept_grp | input | 1 | Also accept group destination addresses |
| irq_glb_en | input | 1 | Global interrupt enable |
| irq_wake_en | input | 1 | Wake interrupt enable |
| pme_glb_en | input | 1 | Power-management event enable |
| pme_wake_en | input | 1 | Wake-to-event enable |
| led_wake_sel | input | 4 | Per-LED select of the wake indication |
| flag_clr | input | 1 | Write-one-to-clear pulse for the flag |
| wake_flag | output | 1 | Sticky wake-frame status |
| irq_o | output | 1 | Interrupt request |
| pme_o | output | 1 | Power-management event |
| led_o | output | 4 | LED outputs |

## Verification
The flag is registered. It changes on the clock edge that captures the `rx_eof` byte, or the `flag_clr` pulse, and is visible from that edge on. The interrupt, event and LED outputs follow the flag combinationally in the same cycle. The bench drives each byte just after a rising edge and samples at the falling edge after the edge that captures the last byte or the clear. This places each check in the first cycle its result is due. Random frames are scored against a bench function that applies the address and pattern rules byte by byte. Directed frames cover the following cases:
- a sync run longer than six bytes
- a restart after a mismatch
- a pattern split across two frames
- a pattern with only fifteen copies
- a pattern built from a foreign address
- a clear in the same cycle as a set

// File: rtl/mpkt_pkg.sv
package mpkt_pkg;
   localparam int OCTET_W = 8;
   typedef logic [OCTET_W-1:0] octet_t;
   localparam octet_t SYNC_OCTET = 8'hFF;
endpackage

// File: rtl/mpkt_da_filter.sv
module mpkt_da_filter
   import mpkt_pkg::*;
#(
   parameter int ADDR_BYTES = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rx_vld,
   input  logic                          rx_sof,
   input  octet_t                        rx_byte,
   input  logic [ADDR_BYTES*OCTET_W-1:0] stn_mac,
   input  logic                          accept_grp,
   output logic                          payload_byte,
   output logic                          da_ok
);
   localparam int IW = $clog2(ADDR_BYTES + 1);

   logic [IW-1:0] idx_q, idx_e;
   logic          eq_q, grp_q;
   octet_t        mac_b [ADDR_BYTES];
   octet_t        exp_b;

   for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_mac
      assign mac_b[k] = stn_mac[k*OCTET_W +: OCTET_W];
   end

   assign idx_e        = rx_sof ? '0 : idx_q;
   assign payload_byte = rx_vld && (idx_e == IW'(ADDR_BYTES));

   always_comb begin
      exp_b = '0;
      for (int k = 0; k < ADDR_BYTES; k++)
         if (idx_e == IW'(k)) exp_b = mac_b[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         eq_q  <= 1'b0;
         grp_q <= 1'b0;
      end else if (rx_vld && (idx_e < IW'(ADDR_BYTES))) begin
         idx_q <= idx_e + IW'(1);
         eq_q  <= ((idx_e == '0) ? 1'b1 : eq_q) & (rx_byte == exp_b);
         if (idx_e == '0) grp_q <= rx_byte[0];
      end else if (rx_sof) begin
         idx_q <= '0;
      end
   end

   assign da_ok = (idx_q == IW'(ADDR_BYTES)) && (eq_q || (accept_grp && grp_q));

   // R1: a payload byte is only seen once the full address has been taken
   p_payload_after_da_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (payload_byte && !rx_sof) |-> (idx_q == IW'(ADDR_BYTES)));
endmodule

// File: rtl/mpkt_pattern_seq.sv
module mpkt_pattern_seq
   import mpkt_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int SYNC_LEN   = 6,
   parameter int REPS       = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rx_sof,
   input  logic                          payload_byte,
   input  octet_t                        rx_byte,
   input  logic [ADDR_BYTES*OCTET_W-1:0] stn_mac,
   output logic                          frame_hit
);
   localparam int TOT = ADDR_BYTES * REPS;
   localparam int SW  = $clog2(SYNC_LEN + 1);
   localparam int PW  = $clog2(TOT + 1);
   localparam int BW  = $clog2(ADDR_BYTES);

   logic [SW-1:0] sync_q, sync_e, sync_n;
   logic [PW-1:0] pos_q, pos_e, pos_n;
   logic [BW-1:0] boff_q, boff_e, boff_n;
   logic          found_q, found_e, hit;
   logic          is_ff, sync_full;
   octet_t        mac_b [ADDR_BYTES];
   octet_t        exp_b;

   for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_mac
      assign mac_b[k] = stn_mac[k*OCTET_W +: OCTET_W];
   end

   assign sync_e    = rx_sof ? '0 : sync_q;
   assign pos_e     = rx_sof ? '0 : pos_q;
   assign boff_e    = rx_sof ? '0 : boff_q;
   assign found_e   = rx_sof ? 1'b0 : found_q;
   assign is_ff     = (rx_byte == SYNC_OCTET);
   assign sync_full = (sync_e == SW'(SYNC_LEN));

   always_comb begin
      exp_b = '0;
      for (int k = 0; k < ADDR_BYTES; k++)
         if (boff_e == BW'(k)) exp_b = mac_b[k];
   end

   always_comb begin
      sync_n = sync_e;
      pos_n  = pos_e;
      boff_n = boff_e;
      hit    = 1'b0;
      if (payload_byte && !found_e) begin
         if (!sync_full) begin
            sync_n = is_ff ? sync_e + SW'(1) : '0;
         end else if (rx_byte == exp_b) begin
            if (pos_e == PW'(TOT - 1)) begin
               hit    = 1'b1;
               pos_n  = '0;
               boff_n = '0;
            end else begin
               pos_n  = pos_e + PW'(1);
               boff_n = (boff_e == BW'(ADDR_BYTES - 1)) ? '0 : boff_e + BW'(1);
            end
         end else if (!((pos_e == '0) && is_ff)) begin
            pos_n  = '0;
            boff_n = '0;
            sync_n = is_ff ? SW'(1) : '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q  <= '0;
         pos_q   <= '0;
         boff_q  <= '0;
         found_q <= 1'b0;
      end else begin
         sync_q  <= sync_n;
         pos_q   <= pos_n;
         boff_q  <= boff_n;
         found_q <= found_e | hit;
      end
   end

   assign frame_hit = found_e | hit;

   // R3: the last address byte only lands after a complete sync run
   p_hit_after_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (sync_q == SW'(SYNC_LEN)));
   // R5: a start of frame throws away an earlier detection
   p_sof_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_sof |=> !found_q);
endmodule

// File: rtl/mpkt_flag_ctl.sv
module mpkt_flag_ctl #(
   parameter int NUM_LED = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_i,
   input  logic               clr_i,
   input  logic               irq_glb_en,
   input  logic               irq_wake_en,
   input  logic               pme_glb_en,
   input  logic               pme_wake_en,
   input  logic [NUM_LED-1:0] led_sel,
   output logic               flag_o,
   output logic               irq_o,
   output logic               pme_o,
   output logic [NUM_LED-1:0] led_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
   assign irq_o  = flag_q & irq_glb_en & irq_wake_en;
   assign pme_o  = flag_q & pme_glb_en & pme_wake_en;

   for (genvar i = 0; i < NUM_LED; i++) begin : g_led
      assign led_o[i] = flag_q & led_sel[i];
   end

   // R6: sticky until cleared
   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i) |=> flag_q);
   // R6: a clear without a set empties the flag
   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_q);
   // R6: a set wins over a clear in the same cycle
   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q);
endmodule

// File: rtl/mpkt_wake_det.sv
module mpkt_wake_det
   import mpkt_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int SYNC_LEN   = 6,
   parameter int REPS       = 16,
   parameter int NUM_LED    = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rx_vld,
   input  logic                          rx_sof,
   input  logic                          rx_eof,
   input  logic [OCTET_W-1:0]            rx_byte,
   input  logic [ADDR_BYTES*OCTET_W-1:0] stn_mac,
   input  logic                          accept_grp,
   input  logic                          irq_glb_en,
   input  logic                          irq_wake_en,
   input  logic                          pme_glb_en,
   input  logic                          pme_wake_en,
   input  logic [NUM_LED-1:0]            led_wake_sel,
   input  logic                          flag_clr,
   output logic                          wake_flag,
   output logic                          irq_o,
   output logic                          pme_o,
   output logic [NUM_LED-1:0]            led_o
);
   if (ADDR_BYTES < 2) begin : g_bad_addr
      $error("ADDR_BYTES must be at least 2");
   end
   if (SYNC_LEN < 1) begin : g_bad_sync
      $error("SYNC_LEN must be at least 1");
   end
   if (REPS < 1) begin : g_bad_reps
      $error("REPS must be at least 1");
   end
   if (NUM_LED < 1) begin : g_bad_led
      $error("NUM_LED must be at least 1");
   end

   logic payload_byte, da_ok, frame_hit, in_frame_q, frame_on, set_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                in_frame_q <= 1'b0;
      else if (rx_vld && rx_eof) in_frame_q <= 1'b0;
      else if (rx_vld && rx_sof) in_frame_q <= 1'b1;
   end

   assign frame_on = rx_sof | in_frame_q;
   assign set_flag = rx_vld && rx_eof && frame_on && !rx_sof && da_ok && frame_hit;

   mpkt_da_filter #(.ADDR_BYTES(ADDR_BYTES)) u_da (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_vld       (rx_vld),
      .rx_sof       (rx_sof),
      .rx_byte      (rx_byte),
      .stn_mac      (stn_mac),
      .accept_grp   (accept_grp),
      .payload_byte (payload_byte),
      .da_ok        (da_ok)
   );

   mpkt_pattern_seq #(.ADDR_BYTES(ADDR_BYTES), .SYNC_LEN(SYNC_LEN), .REPS(REPS)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_sof       (rx_sof),
      .payload_byte (payload_byte),
      .rx_byte      (rx_byte),
      .stn_mac      (stn_mac),
      .frame_hit    (frame_hit)
   );

   mpkt_flag_ctl #(.NUM_LED(NUM_LED)) u_flag (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_i       (set_flag),
      .clr_i       (flag_clr),
      .irq_glb_en  (irq_glb_en),
      .irq_wake_en (irq_wake_en),
      .pme_glb_en  (pme_glb_en),
      .pme_wake_en (pme_wake_en),
      .led_sel     (led_wake_sel),
      .flag_o      (wake_flag),
      .irq_o       (irq_o),
      .pme_o       (pme_o),
      .led_o       (led_o)
   );

   // R5: the flag only rises on the edge that takes an end-of-frame byte
   p_rise_on_eof_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_flag) |-> $past(rx_eof));
   // R7: no interrupt without the status flag
   p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> wake_flag);
   // R8: no event without the status flag
   p_pme_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pme_o |-> wake_flag);
endmodule

// File: tb/tb_mpkt_wake_det.sv
module tb_mpkt_wake_det;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_vld = 0, rx_sof = 0, rx_eof = 0;
   logic [7:0]  rx_byte = '0;
   logic [47:0] stn_mac = 48'h9F7E5D3C1A02;
   logic        accept_grp = 0, irq_glb_en = 1, irq_wake_en = 1;
   logic        pme_glb_en = 1, pme_wake_en = 1, flag_clr = 0;
   logic [3:0]  led_wake_sel = 4'hF;
   logic        wake_flag, irq_o, pme_o;
   logic [3:0]  led_o;

   localparam logic [47:0] OTHER = 48'h665544332210;

   int n_chk = 0, n_fail = 0;
   logic [7:0] fb [0:255];
   int flen = 0;

   always #5 clk = ~clk;

   mpkt_wake_det dut (
      .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_eof(rx_eof),
      .rx_byte(rx_byte), .stn_mac(stn_mac), .accept_grp(accept_grp),
      .irq_glb_en(irq_glb_en), .irq_wake_en(irq_wake_en),
      .pme_glb_en(pme_glb_en), .pme_wake_en(pme_wake_en),
      .led_wake_sel(led_wake_sel), .flag_clr(flag_clr),
      .wake_flag(wake_flag), .irq_o(irq_o), .pme_o(pme_o), .led_o(led_o));

   task automatic chk(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_outs(input string req, input bit ef);
      chk(req, "wake_flag", {3'b0, wake_flag}, {3'b0, ef});
      chk("R7", "irq_o", {3'b0, irq_o}, {3'b0, ef & irq_glb_en & irq_wake_en});
      chk("R8", "pme_o", {3'b0, pme_o}, {3'b0, ef & pme_glb_en & pme_wake_en});
      chk("R9", "led_o", led_o, {4{ef}} & led_wake_sel);
   endtask

   task automatic put(input logic [7:0] b);
      fb[flen] = b;
      flen++;
   endtask

   task automatic put_mac(input logic [47:0] m);
      for (int k = 0; k < 6; k++) put(m[8*k +: 8]);
   endtask

   task automatic put_pat(input logic [47:0] m, input int sync, input int reps);
      for (int k = 0; k < sync; k++) put(8'hFF);
      for (int r = 0; r < reps; r++) put_mac(m);
   endtask

   function automatic bit model_det(input bit ag, input logic [47:0] m);
      bit eq = 1;
      int sync = 0, pos = 0;
      if (flen < 7) return 0;
      for (int k = 0; k < 6; k++) if (fb[k] != m[8*k +: 8]) eq = 0;
      if (!(eq || (ag && fb[0][0]))) return 0;
      for (int i = 6; i < flen; i++) begin
         if (sync < 6) sync = (fb[i] == 8'hFF) ? sync + 1 : 0;
         else if (fb[i] == m[8*(pos % 6) +: 8]) begin
            pos++;
            if (pos == 96) return 1;
         end else if (!(pos == 0 && fb[i] == 8'hFF)) begin
            pos = 0;
            sync = (fb[i] == 8'hFF) ? 1 : 0;
         end
      end
      return 0;
   endfunction

   task automatic send(input bit clr_at_eof, input bit gaps);
      for (int i = 0; i < flen; i++) begin
         if (gaps && i > 0 && ($urandom % 4 == 0)) begin
            @(posedge clk); #1;
            rx_vld = 0; rx_sof = 0; rx_eof = 0; flag_clr = 0;
         end
         @(posedge clk); #1;
         rx_vld = 1; rx_byte = fb[i];
         rx_sof = (i == 0); rx_eof = (i == flen - 1);
         flag_clr = clr_at_eof && (i == flen - 1);
      end
      @(posedge clk); #1;
      rx_vld = 0; rx_sof = 0; rx_eof = 0; flag_clr = 0;
      @(negedge clk);
   endtask

   task automatic clear_flag();
      @(posedge clk); #1 flag_clr = 1;
      @(posedge clk); #1 flag_clr = 0;
      @(negedge clk);
      chk("R6", "flag after clear", {3'b0, wake_flag}, 4'h0);
   endtask

   task automatic run(input string req, input bit ag, input bit exp);
      accept_grp = ag;
      send(0, 0);
      chk_outs(req, exp);
      chk(req, "model agrees", {3'b0, model_det(ag, stn_mac)}, {3'b0, exp});
      clear_flag();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk_outs("R10", 0);

      // R1: exact station address with pattern
      flen = 0; put_mac(stn_mac); put_mac(OTHER); put_pat(stn_mac, 6, 16);
      run("R1", 0, 1);
      // R1: foreign unicast address rejected
      flen = 0; put_mac(OTHER); put_pat(stn_mac, 6, 16);
      run("R1", 1, 0);
      // R2: broadcast needs accept_grp
      flen = 0; put_mac(48'hFFFFFFFFFFFF); put_pat(stn_mac, 6, 16);
      run("R2", 0, 0);
      flen = 0; put_mac(48'hFFFFFFFFFFFF); put_pat(stn_mac, 6, 16);
      run("R2", 1, 1);
      flen = 0; put_mac(48'h0000005E0001); put_pat(stn_mac, 6, 16);
      run("R2", 1, 1);
      // R4: pattern of a foreign address under broadcast
      flen = 0; put_mac(48'hFFFFFFFFFFFF); put_pat(OTHER, 6, 16);
      run("R4", 1, 0);
      // R3: fifteen copies are not enough
      flen = 0; put_mac(stn_mac); put_pat(stn_mac, 6, 15); put(8'h00);
      run("R3", 0, 0);
      // R3: long sync run plus trailing bytes
      flen = 0; put_mac(stn_mac); put(8'h12); put_pat(stn_mac, 9, 16); put(8'h33); put(8'h44);
      run("R3", 0, 1);
      // R3: mismatch in copy five restarts; full pattern afterwards
      flen = 0; put_mac(stn_mac); put_pat(stn_mac, 6, 4); put(8'hFF); put_pat(stn_mac, 5, 16);
      run("R3", 0, 1);
      // R3: short sync run rejected
      flen = 0; put_mac(stn_mac); put_pat(stn_mac, 5, 16);
      run("R3", 0, 0);
      // R5: pattern split across two frames
      flen = 0; put_mac(stn_mac); put_pat(stn_mac, 6, 8);
      run("R5", 0, 0);
      flen = 0; put_mac(stn_mac); put_pat(stn_mac, 0, 8);
      run("R5", 0, 0);

      // R6: sticky flag and set wins over clear
      flen = 0; put_mac(stn_mac); put_pat(stn_mac, 6, 16);
      accept_grp = 0;
      send(1, 0);
      chk("R6", "set wins over clear", {3'b0, wake_flag}, 4'h1);
      repeat (5) @(negedge clk);
      chk("R6", "sticky", {3'b0, wake_flag}, 4'h1);
      // R7/R8/R9 enable combinations while flag held
      for (int e = 0; e < 16; e++) begin
         {irq_glb_en, irq_wake_en, pme_glb_en, pme_wake_en} = 4'(e);
         led_wake_sel = 4'(e * 5);
         @(negedge clk);
         chk_outs("R6", 1);
      end
      clear_flag();

      // random frames
      for (int it = 0; it < 60; it++) begin
         int dsel, pk;
         bit ag, exp;
         logic [47:0] r;
         ag = 1'($urandom);
         {irq_glb_en, irq_wake_en, pme_glb_en, pme_wake_en} = 4'($urandom);
         led_wake_sel = 4'($urandom);
         flen = 0;
         dsel = $urandom % 4;
         r = {$urandom, $urandom};
         case (dsel)
            0: put_mac(stn_mac);
            1: put_mac(48'hFFFFFFFFFFFF);
            2: put_mac({r[47:1], 1'b1});
            default: put_mac({r[47:1], 1'b0});
         endcase
         for (int k = 0; k < int'($urandom % 8); k++) put(8'($urandom));
         put_pat(($urandom % 4 == 0) ? OTHER : stn_mac, 6 + int'($urandom % 2), 16);
         if ($urandom % 3 == 0) begin
            pk = 6 + int'($urandom % (flen - 6));
            fb[pk] = 8'($urandom);
         end
         for (int k = 0; k < int'($urandom % 5); k++) put(8'($urandom));
         exp = model_det(ag, stn_mac);
         accept_grp = ag;
         send(0, 1);
         chk_outs(exp ? "R3" : "R1", exp);
         clear_flag();
      end
      summary();
   end
endmodule